// File: doc/BRIEF.md
# I2S to Simultaneous Ladder-DAC Driver

This block takes a standard I2S stream and turns it into the serial form that non-oversampling resistor-ladder DACs expect. That form has one shared output bit clock, a separate data line for each channel and a latch strobe. Every flop runs on the master clock. The incoming I2S bit clock, word select and data are brought in through synchronisers and sampled as plain data. A rising edge of the I2S bit clock is found with an edge detector. Each incoming word is collected MSB-aligned into a 24-bit register.

When a complete left/right pair has arrived, a sequencer loads both words and shifts them out together, MSB first, at half the master-clock rate. It can add one leading clock pulse before the data. After the last bit it pulls the latch strobe low for a fixed number of master cycles, so both converters update on the same edge. It can then add a programmable number of tail pulses, after which the output clock stays idle. In dual-mono mode one chosen channel goes to both data lines. Every output leaves through a final register stage, so all output edges line up on the same master-clock edge.

Top module: `i2s_ladder_driver`

## Requirements
- R1: `cfg_width` selects the output word length: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 bits. The word is sent MSB first and is the top N bits of the 24-bit MSB-aligned captured sample.
- R2: `out_dl` and `out_dr` change only while `out_bck` is low, and they hold their value across every rising edge of `out_bck`.
- R3: After the last data bit of a frame, `out_le` goes low for exactly LE_CYCLES master cycles, and `out_bck` stays low during that time. Each accepted frame gives exactly one such pulse.
- R4: Between frames `out_bck` stays low. A frame emits no rising edges other than the leading, data and tail pulses.
- R5: With `cfg_tail_en`=1, exactly `cfg_tail_cnt` pulses of `out_bck` follow the rising edge of `out_le`. A count of 0 gives none. With `cfg_tail_en`=0 no pulse follows the latch.
- R6: With `cfg_lead_en`=1, one extra pulse with data 0 comes before the MSB, so N+1 rising edges come before the latch. With `cfg_lead_en`=0, N rising edges come before the latch.
- R7: With `cfg_mono_en`=1, both data lines carry the same channel: left when `cfg_mono_sel`=0, right when it is 1. With `cfg_mono_en`=0, `out_dl` carries the left sample and `out_dr` the right sample.
- R8: The I2S input follows the standard convention. Word select low marks the left channel. The MSB comes one bit clock after a word-select change. Bits are taken on the rising edge of the I2S bit clock. Bits past the 24th in a slot are ignored, and a slot shorter than 24 bits is zero-filled below.
- R9: Output starts only after a left word and then a right word have both been captured. The partial words before the first word-select change after reset are thrown away.
- R10: A pair that completes while the sequencer is still busy with an earlier frame is dropped without effect.
- R11: In reset, and after it until the first frame, `out_bck`=0, `out_dl`=0, `out_dr`=0 and `out_le`=1.
- R12: While active, `out_bck` is high for one master cycle and low for at least one master cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_bck | input | 1 | I2S bit clock, sampled as data |
| i2s_ws | input | 1 | I2S word select, low for left |
| i2s_sd | input | 1 | I2S serial data |
| cfg_width | input | 2 | Output word-length code |
| cfg_lead_en | input | 1 | Enable one leading pulse |
| cfg_tail_en | input | 1 | Enable tail pulses after latch |
| cfg_tail_cnt | input | TAIL_W | Number of tail pulses |
| cfg_mono_en | input | 1 | Dual-mono routing enable |
| cfg_mono_sel | input | 1 | Dual-mono channel: 0 left, 1 right |
| out_bck | output | 1 | Shared output bit clock |
| out_dl | output | 1 | Left (or mono) data line |
| out_dr | output | 1 | Right (or mono) data line |
| out_le | output | 1 | Latch strobe, active low |

## Verification
A table of frames covers each word length with different left and right patterns, so a swapped channel or a shifted bit position shows up in the captured bit stream. Each frame pads its 32-bit slot with nonzero bits below bit 24, which exposes any capture that spills past the 24th bit. The same frames also vary the leading pulse, the tail setting (enabled, enabled with count zero, disabled with a nonzero count) and both dual-mono selections. Counting rising edges before and after the latch tells these options apart. Directed runs cover the frame discarded after reset and a burst of short, fast I2S frames, where only the first and third pair may produce a latch.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_DATA,
        SQ_LATCH,
        SQ_TAIL
    } seq_state_e;

    // word-length code to number of output bits
    function automatic logic [4:0] width_bits(input logic [1:0] code);
        case (code)
            2'd0:    width_bits = 5'd16;
            2'd1:    width_bits = 5'd18;
            2'd2:    width_bits = 5'd20;
            default: width_bits = 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/i2s_capture.sv
module i2s_capture #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i2s_bck,
    input  logic          i2s_ws,
    input  logic          i2s_sd,
    output logic          frame_vld,
    output logic [DW-1:0] frame_l,
    output logic [DW-1:0] frame_r
);
    localparam int IW = $clog2(DW + 1);
    localparam logic [IW-1:0] IDX_END = IW'(DW);
    localparam logic [IW-1:0] IDX_TOP = IW'(DW - 1);

    typedef struct packed {
        logic [2:0]    bck_sy;
        logic [1:0]    ws_sy;
        logic [1:0]    sd_sy;
        logic          ws_prev;
        logic          synced;
        logic [IW-1:0] idx;
        logic [DW-1:0] acc;
        logic [DW-1:0] hold_l;
        logic          have_l;
        logic          vld;
        logic [DW-1:0] out_l;
        logic [DW-1:0] out_r;
    } cap_t;

    cap_t cap_d, cap_q;

    logic          bck_rise;
    logic          ws_now;
    logic          sd_now;
    logic [DW-1:0] word_w;

    always_comb begin
        cap_d        = cap_q;
        cap_d.vld    = 1'b0;
        cap_d.bck_sy = {cap_q.bck_sy[1:0], i2s_bck};
        cap_d.ws_sy  = {cap_q.ws_sy[0], i2s_ws};
        cap_d.sd_sy  = {cap_q.sd_sy[0], i2s_sd};

        bck_rise = cap_q.bck_sy[1] & ~cap_q.bck_sy[2];
        ws_now   = cap_q.ws_sy[1];
        sd_now   = cap_q.sd_sy[1];

        word_w = cap_q.acc;
        if (cap_q.idx < IDX_END) begin
            word_w[IDX_TOP - cap_q.idx] = sd_now;
        end

        if (bck_rise) begin
            if (ws_now != cap_q.ws_prev) begin
                // this bit is the LSB of the word that is ending
                if (cap_q.synced) begin
                    if (!cap_q.ws_prev) begin
                        cap_d.hold_l = word_w;
                        cap_d.have_l = 1'b1;
                    end else if (cap_q.have_l) begin
                        cap_d.vld    = 1'b1;
                        cap_d.out_l  = cap_q.hold_l;
                        cap_d.out_r  = word_w;
                        cap_d.have_l = 1'b0;
                    end
                end
                cap_d.synced  = 1'b1;
                cap_d.ws_prev = ws_now;
                cap_d.idx     = '0;
                cap_d.acc     = '0;
            end else begin
                cap_d.acc = word_w;
                if (cap_q.idx < IDX_END) begin
                    cap_d.idx = cap_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign frame_vld = cap_q.vld;
    assign frame_l   = cap_q.out_l;
    assign frame_r   = cap_q.out_r;

endmodule

// File: rtl/ladder_sequencer.sv
module ladder_sequencer
    import ladder_pkg::*;
#(
    parameter int DW        = 24,
    parameter int TAIL_W    = 4,
    parameter int LE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld,
    input  logic [DW-1:0]     frame_l,
    input  logic [DW-1:0]     frame_r,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_lead_en,
    input  logic              cfg_tail_en,
    input  logic [TAIL_W-1:0] cfg_tail_cnt,
    input  logic              cfg_mono_en,
    input  logic              cfg_mono_sel,
    output logic              seq_bck,
    output logic              seq_dl,
    output logic              seq_dr,
    output logic              seq_le
);
    localparam int LW    = $clog2(LE_CYCLES + 1);
    localparam int CNT_W = (TAIL_W > LW) ? TAIL_W : LW;
    localparam int BW    = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LE_LOAD = CNT_W'(LE_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             ph;
        logic [BW-1:0]    bits;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    shl;
        logic [DW-1:0]    shr;
        logic             tail_en;
        logic [TAIL_W-1:0] tail_n;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [DW-1:0] mono_w;

    always_comb begin
        seq_d  = seq_q;
        mono_w = cfg_mono_sel ? frame_r : frame_l;

        case (seq_q.st)
            SQ_IDLE: begin
                // pairs arriving in any other state are dropped
                if (frame_vld) begin
                    seq_d.shl     = cfg_mono_en ? mono_w : frame_l;
                    seq_d.shr     = cfg_mono_en ? mono_w : frame_r;
                    seq_d.bits    = BW'(width_bits(cfg_width) - 5'd1);
                    seq_d.tail_en = cfg_tail_en;
                    seq_d.tail_n  = cfg_tail_cnt;
                    seq_d.ph      = 1'b0;
                    seq_d.st      = cfg_lead_en ? SQ_LEAD : SQ_DATA;
                end
            end
            SQ_LEAD: begin
                seq_d.ph = ~seq_q.ph;
                if (seq_q.ph) begin
                    seq_d.st = SQ_DATA;
                end
            end
            SQ_DATA: begin
                seq_d.ph = ~seq_q.ph;
                if (seq_q.ph) begin
                    if (seq_q.bits == '0) begin
                        seq_d.st  = SQ_LATCH;
                        seq_d.cnt = LE_LOAD;
                    end else begin
                        seq_d.bits = seq_q.bits - 1'b1;
                        seq_d.shl  = {seq_q.shl[DW-2:0], 1'b0};
                        seq_d.shr  = {seq_q.shr[DW-2:0], 1'b0};
                    end
                end
            end
            SQ_LATCH: begin
                if (seq_q.cnt == '0) begin
                    if (seq_q.tail_en && (seq_q.tail_n != '0)) begin
                        seq_d.st  = SQ_TAIL;
                        seq_d.ph  = 1'b0;
                        seq_d.cnt = CNT_W'(seq_q.tail_n) - 1'b1;
                    end else begin
                        seq_d.st = SQ_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_TAIL: begin
                seq_d.ph = ~seq_q.ph;
                if (seq_q.ph) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.st = SQ_IDLE;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seq_bck = seq_q.ph && ((seq_q.st == SQ_LEAD) || (seq_q.st == SQ_DATA) ||
                                  (seq_q.st == SQ_TAIL));
    assign seq_dl  = (seq_q.st == SQ_DATA) && seq_q.shl[DW-1];
    assign seq_dr  = (seq_q.st == SQ_DATA) && seq_q.shr[DW-1];
    assign seq_le  = (seq_q.st != SQ_LATCH);

endmodule

// File: rtl/out_retime.sv
module out_retime #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pin_d, pin_q;

    always_comb begin
        pin_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= RST_VAL;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign dout = pin_q;

endmodule

// File: rtl/i2s_ladder_driver.sv
module i2s_ladder_driver #(
    parameter int SAMPLE_W  = 24,
    parameter int TAIL_W    = 4,
    parameter int LE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i2s_bck,
    input  logic              i2s_ws,
    input  logic              i2s_sd,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_lead_en,
    input  logic              cfg_tail_en,
    input  logic [TAIL_W-1:0] cfg_tail_cnt,
    input  logic              cfg_mono_en,
    input  logic              cfg_mono_sel,
    output logic              out_bck,
    output logic              out_dl,
    output logic              out_dr,
    output logic              out_le
);
    localparam int PINS = 4;

    logic                frame_vld;
    logic [SAMPLE_W-1:0] frame_l;
    logic [SAMPLE_W-1:0] frame_r;
    logic                seq_bck, seq_dl, seq_dr, seq_le;
    logic [PINS-1:0]     pins_out;

    i2s_capture #(.DW(SAMPLE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .i2s_bck   (i2s_bck),
        .i2s_ws    (i2s_ws),
        .i2s_sd    (i2s_sd),
        .frame_vld (frame_vld),
        .frame_l   (frame_l),
        .frame_r   (frame_r)
    );

    ladder_sequencer #(
        .DW        (SAMPLE_W),
        .TAIL_W    (TAIL_W),
        .LE_CYCLES (LE_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_vld    (frame_vld),
        .frame_l      (frame_l),
        .frame_r      (frame_r),
        .cfg_width    (cfg_width),
        .cfg_lead_en  (cfg_lead_en),
        .cfg_tail_en  (cfg_tail_en),
        .cfg_tail_cnt (cfg_tail_cnt),
        .cfg_mono_en  (cfg_mono_en),
        .cfg_mono_sel (cfg_mono_sel),
        .seq_bck      (seq_bck),
        .seq_dl       (seq_dl),
        .seq_dr       (seq_dr),
        .seq_le       (seq_le)
    );

    // final stage: bck, dl, dr, le leave on one master edge
    out_retime #(.W(PINS), .RST_VAL(4'b0001)) u_rt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({seq_bck, seq_dl, seq_dr, seq_le}),
        .dout  (pins_out)
    );

    assign out_bck = pins_out[3];
    assign out_dl  = pins_out[2];
    assign out_dr  = pins_out[1];
    assign out_le  = pins_out[0];

endmodule

// File: rtl/ladder_driver_chk.sv
module ladder_driver_chk #(
    parameter int LE_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic out_bck,
    input logic out_dl,
    input logic out_dr,
    input logic out_le
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!out_le) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R12
    bck_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bck |=> !out_bck);

    // R2
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_bck) |-> ($stable(out_dl) && $stable(out_dr)));

    // R3
    latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_le |-> !out_bck);

    // R3
    latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_le) |-> (low_run == 16'(LE_CYCLES)));

endmodule

bind i2s_ladder_driver ladder_driver_chk #(.LE_CYCLES(LE_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_bck (out_bck),
    .out_dl  (out_dl),
    .out_dr  (out_dr),
    .out_le  (out_le)
);

// File: tb/i2s_ladder_driver_bench.sv
module i2s_ladder_driver_bench;
    localparam int LE_CYCLES = 4;

    typedef struct packed {
        logic [23:0] l;
        logic [23:0] r;
        logic [1:0]  wc;
        logic        lead;
        logic        ten;
        logic [3:0]  tn;
        logic        mono;
        logic        sel;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{24'hA5C3F1, 24'h1E2D3C, 2'd3, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0},
        '{24'h8001F0, 24'h7FFE0F, 2'd0, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0},
        '{24'h3C96A5, 24'hC3695A, 2'd1, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0},
        '{24'hF0F0F0, 24'h0F0F0F, 2'd2, 1'b1, 1'b0, 4'd7,  1'b0, 1'b0},
        '{24'h123456, 24'hFEDCBA, 2'd3, 1'b0, 1'b1, 4'd15, 1'b1, 1'b0},
        '{24'h5A5A5A, 24'hB4C2E1, 2'd0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i2s_bck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
    logic [1:0] cfg_width = 2'd3;
    logic cfg_lead_en = 1'b0, cfg_tail_en = 1'b0;
    logic [3:0] cfg_tail_cnt = 4'd0;
    logic cfg_mono_en = 1'b0, cfg_mono_sel = 1'b0;
    logic out_bck, out_dl, out_dr, out_le;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // output monitor state
    int pre_cnt = 0, post_cnt = 0, le_low = 0, le_falls = 0;
    bit latched = 1'b0;
    logic [31:0] rec_l = '0, rec_r = '0;
    logic prev_bck = 1'b0, prev_le = 1'b1;

    always #2 clk = ~clk;

    i2s_ladder_driver #(.LE_CYCLES(LE_CYCLES)) u_i2s_ladder_driver (
        .clk          (clk),
        .rst_n        (rst_n),
        .i2s_bck      (i2s_bck),
        .i2s_ws       (i2s_ws),
        .i2s_sd       (i2s_sd),
        .cfg_width    (cfg_width),
        .cfg_lead_en  (cfg_lead_en),
        .cfg_tail_en  (cfg_tail_en),
        .cfg_tail_cnt (cfg_tail_cnt),
        .cfg_mono_en  (cfg_mono_en),
        .cfg_mono_sel (cfg_mono_sel),
        .out_bck      (out_bck),
        .out_dl       (out_dl),
        .out_dr       (out_dr),
        .out_le       (out_le)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_bck && !prev_bck) begin
                if (!latched) begin
                    rec_l = {rec_l[30:0], out_dl};
                    rec_r = {rec_r[30:0], out_dr};
                    pre_cnt++;
                end else begin
                    post_cnt++;
                end
            end
            if (!out_le) begin
                le_low++;
                latched = 1'b1;
                if (prev_le) le_falls++;
            end
        end
        prev_bck = out_bck;
        prev_le  = out_le;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic mon_clear();
        pre_cnt = 0; post_cnt = 0; le_low = 0; latched = 1'b0;
        rec_l = '0; rec_r = '0;
    endtask

    task automatic send_bit(input logic w, input logic d, input int half);
        i2s_bck = 1'b0; i2s_ws = w; i2s_sd = d;
        repeat (half) @(negedge clk);
        i2s_bck = 1'b1;
        repeat (half) @(negedge clk);
    endtask

    // standard I2S: ws changes together with the LSB of the ending word
    task automatic send_frame(input logic [31:0] l, input logic [31:0] r,
                              input int slot, input int half);
        for (int i = 0; i < slot; i++) send_bit(i == slot - 1, l[31-i], half);
        for (int i = 0; i < slot; i++) send_bit(i != slot - 1, r[31-i], half);
        i2s_bck = 1'b0;
    endtask

    function automatic int nbits(input logic [1:0] c);
        case (c)
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values while held
        chk(out_bck == 1'b0 && out_le == 1'b1 && out_dl == 1'b0 && out_dr == 1'b0,
            "R11 reset", {28'd0, out_bck, out_dl, out_dr, out_le}, 32'h1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(out_bck == 1'b0 && out_le == 1'b1 && out_dl == 1'b0 && out_dr == 1'b0,
            "R11 after reset", {28'd0, out_bck, out_dl, out_dr, out_le}, 32'h1);

        // R9: first frame after reset is partial and must not latch
        mon_clear(); le_falls = 0;
        send_frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32, 4);
        repeat (200) @(negedge clk);
        chk(le_falls == 0, "R9 sync discard", le_falls, 0);

        // table of frames: R1 R4 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            automatic vec_t t = VEC[v];
            automatic int n = nbits(t.wc);
            automatic logic [23:0] el = t.mono ? (t.sel ? t.r : t.l) : t.l;
            automatic logic [23:0] er = t.mono ? (t.sel ? t.r : t.l) : t.r;
            automatic logic [31:0] mask = (32'd1 << n) - 32'd1;
            automatic logic [31:0] xl = 32'(el) >> (24 - n);
            automatic logic [31:0] xr = 32'(er) >> (24 - n);
            automatic int xpost = t.ten ? int'(t.tn) : 0;
            cfg_width = t.wc; cfg_lead_en = t.lead; cfg_tail_en = t.ten;
            cfg_tail_cnt = t.tn; cfg_mono_en = t.mono; cfg_mono_sel = t.sel;
            mon_clear();
            // pad below bit 24 with nonzero junk (R8)
            send_frame({t.l, 8'hA7}, {t.r, 8'h5B}, 32, 4);
            repeat (200) @(negedge clk);
            chk(pre_cnt == n + int'(t.lead), "R6 pulses before latch", pre_cnt,
                n + int'(t.lead));
            chk((rec_l & mask) == xl, "R1 R7 R8 left line bits", rec_l & mask, xl);
            chk((rec_r & mask) == xr, "R1 R7 R8 right line bits", rec_r & mask, xr);
            chk(le_low == LE_CYCLES, "R3 latch width", le_low, LE_CYCLES);
            chk(post_cnt == xpost, "R4 R5 tail pulses", post_cnt, xpost);
        end

        // R10: fast short frames, middle pair arrives while busy
        cfg_width = 2'd3; cfg_lead_en = 1'b1; cfg_tail_en = 1'b0;
        cfg_tail_cnt = 4'd0; cfg_mono_en = 1'b0; cfg_mono_sel = 1'b0;
        mon_clear(); le_falls = 0;
        send_frame(32'hFC00_0000, 32'h8400_0000, 6, 2);
        send_frame(32'hA800_0000, 32'h5400_0000, 6, 2);
        send_frame(32'hCC00_0000, 32'h3000_0000, 6, 2);
        repeat (200) @(negedge clk);
        chk(le_falls == 2, "R10 busy drop latch count", le_falls, 2);
        chk(pre_cnt == 25, "R10 first frame pulses", pre_cnt, 25);
        chk(post_cnt == 25, "R10 third frame pulses", post_cnt, 25);
        chk(out_bck == 1'b0 && out_le == 1'b1, "R4 idle after burst",
            {30'd0, out_bck, out_le}, 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule